// File: doc/BRIEF.md
# Floor-bounded pseudo-random victim index for a 16-entry translation buffer

This block supplies the entry number that a random-replacement write into a 16-entry translation buffer should overwrite. It holds two pieces of state: a down-counter that gives the victim index, and a floor register that sets the lowest index the counter may produce. Entries below the floor are locked. A random-replacement write can never select them, so software can reach them only through an indexed write. The block decides nothing about when a write happens, and it holds no translation storage.

The counter moves down through the window from the floor up to the top index, and wraps back to the top. On a given cycle it may skip its step. A 16-bit linear feedback shift register makes that choice, so the sequence of victims does not repeat in lock-step with the software loop. This avoids livelock. A strobe from the random-write operation forces a step, so two random writes in a row never land on the same entry. Writing the floor puts the counter back at the top index.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. `rand_idx` is always valid outside reset and may be sampled on any cycle. `wired_rdata` always shows the floor in force.

Top module: `rand_victim_gen`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `rand_idx` is 15 and `wired_rdata` is 0.
- R2: On a clock edge with no floor write and no strobe, `rand_idx` keeps its value if the skip bit is 1.
- R3: On a clock edge with no floor write, the index decreases by exactly one when a step is taken and the index is above the floor. It never changes by any other amount except a wrap to 15.
- R4: A step taken while the index equals the floor (floor 0 to 14) sets the index to 15 on that edge.
- R5: While the floor is 15 or less, `rand_idx` is never below `wired_rdata`.
- R6: A clock edge with `wired_we` high loads `wired_wdata` into the floor and sets `rand_idx` to 15. Both are visible after that edge.
- R7: While the floor is above 15, `rand_idx` stays at 15.
- R8: A clock edge with `rw_sample` high and no floor write always takes a step, whatever the skip bit is. With a floor below 15, the index therefore changes on that edge.
- R9: The skip bit is bit 15 of a 16-bit shift register. The register shifts left each clock edge after reset, including edges with a floor write. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. Its reset value is 0xACE1.
- R10: With the floor at 0, the index visits every entry from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wired_we | input | 1 | Floor write enable |
| wired_wdata | input | 5 | New floor value |
| rw_sample | input | 1 | Strobe from a random-replacement write; forces a step |
| rand_idx | output | 4 | Current victim index |
| wired_rdata | output | 5 | Floor value in force |

## Verification
The bench sweeps the floor over every value from 0 to 17. This separates the normal window, the single-entry window at 15 and the out-of-range floors. At each floor it first runs idle cycles, where the shift register alone decides between hold and step. It then runs cycles with the strobe on every other edge, which tells a forced step apart from a skip. A last run with the floor at 0 checks that the wrap reaches all sixteen entries. A wrong tap or a wrong seed shows up as a hold on a cycle where a step was expected, or a step where a hold was expected.

// File: rtl/rvg_pkg.sv
package rvg_pkg;
  // action chosen by the counter for the coming edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_DEC    = 2'd1,
    ACT_WRAP   = 2'd2,
    ACT_RELOAD = 2'd3
  } ctr_act_e;

  // default skip-source polynomial taps (bits 15,13,12,10) and seed
  localparam logic [15:0] DEF_TAPS = 16'hB400;
  localparam logic [15:0] DEF_SEED = 16'hACE1;
endpackage

// File: rtl/rvg_lfsr.sv
module rvg_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = rvg_pkg::DEF_TAPS,
  parameter logic [W-1:0] SEED = rvg_pkg::DEF_SEED
) (
  input  logic clk,
  input  logic rst_n,
  output logic skip_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {state_q[W-2:0], fb};
  end

  assign skip_o = state_q[W-1];
endmodule

// File: rtl/rvg_floor.sv
module rvg_floor #(
  parameter int WIRED_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [WIRED_W-1:0] wdata_i,
  output logic [WIRED_W-1:0] floor_o,
  output logic               reload_o
);
  logic [WIRED_W-1:0] floor_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    floor_q <= '0;
    else if (we_i) floor_q <= wdata_i;
  end

  assign floor_o  = floor_q;
  assign reload_o = we_i;
endmodule

// File: rtl/rvg_ctr.sv
module rvg_ctr #(
  parameter int IDX_W   = 4,
  parameter int WIRED_W = 5,
  parameter int TOP     = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reload_i,
  input  logic               step_i,
  input  logic [WIRED_W-1:0] floor_i,
  output logic [IDX_W-1:0]   idx_o
);
  import rvg_pkg::*;

  localparam logic [IDX_W-1:0] TOP_I = IDX_W'(TOP);
  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             at_floor;
  ctr_act_e         act;

  // at or below the floor: the next step wraps to the top
  // (a floor above TOP makes this permanently true, pinning the index)
  assign at_floor = {{(WIRED_W-IDX_W){1'b0}}, idx_q} <= floor_i;

  always_comb begin
    if (reload_i)     act = ACT_RELOAD;
    else if (!step_i) act = ACT_HOLD;
    else if (at_floor) act = ACT_WRAP;
    else              act = ACT_DEC;
  end

  always_comb begin
    unique case (act)
      ACT_DEC:    idx_d = idx_q - ONE_I;
      ACT_WRAP:   idx_d = TOP_I;
      ACT_RELOAD: idx_d = TOP_I;
      default:    idx_d = idx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= TOP_I;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/rand_victim_gen.sv
module rand_victim_gen #(
  parameter int NUM_ENTRIES = 16,
  parameter int LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = rvg_pkg::DEF_TAPS,
  parameter logic [LFSR_W-1:0] LFSR_SEED = rvg_pkg::DEF_SEED,
  localparam int IDX_W   = $clog2(NUM_ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wired_we,
  input  logic [WIRED_W-1:0] wired_wdata,
  input  logic               rw_sample,
  output logic [IDX_W-1:0]   rand_idx,
  output logic [WIRED_W-1:0] wired_rdata
);
  localparam int TOP = NUM_ENTRIES - 1;

  logic               skip;
  logic               reload;
  logic               step;
  logic [WIRED_W-1:0] floor_v;

  rvg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .skip_o (skip)
  );

  rvg_floor #(.WIRED_W(WIRED_W)) u_floor (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (wired_we),
    .wdata_i  (wired_wdata),
    .floor_o  (floor_v),
    .reload_o (reload)
  );

  // a strobe overrides a skip so back-to-back random writes differ
  assign step = rw_sample | ~skip;

  rvg_ctr #(.IDX_W(IDX_W), .WIRED_W(WIRED_W), .TOP(TOP)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload),
    .step_i   (step),
    .floor_i  (floor_v),
    .idx_o    (rand_idx)
  );

  assign wired_rdata = floor_v;
endmodule

// File: rtl/rvg_chk.sv
module rvg_chk #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W   = $clog2(NUM_ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wired_we,
  input logic [WIRED_W-1:0] wired_wdata,
  input logic               rw_sample,
  input logic [IDX_W-1:0]   rand_idx,
  input logic [WIRED_W-1:0] wired_rdata
);
  localparam logic [IDX_W-1:0]   TOP_I = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [WIRED_W-1:0] TOP_W = WIRED_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0]   ONE_I = IDX_W'(1);

  logic [WIRED_W-1:0] idx_w;
  assign idx_w = {1'b0, rand_idx};

  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_rdata <= TOP_W) |-> (idx_w >= wired_rdata)); // R5

  AST_RELOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    wired_we |=> (rand_idx == TOP_I && wired_rdata == $past(wired_wdata))); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wired_we |=> (rand_idx == $past(rand_idx) || rand_idx == $past(rand_idx) - ONE_I || rand_idx == TOP_I)); // R3

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_sample && !wired_we && idx_w == wired_rdata) |=> (rand_idx == TOP_I)); // R4

  AST_FORCED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_sample && !wired_we && wired_rdata < TOP_W) |=> (rand_idx != $past(rand_idx))); // R8

  AST_HIGH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_rdata > TOP_W) |-> (rand_idx == TOP_I)); // R7
endmodule

bind rand_victim_gen rvg_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wired_we    (wired_we),
  .wired_wdata (wired_wdata),
  .rw_sample   (rw_sample),
  .rand_idx    (rand_idx),
  .wired_rdata (wired_rdata)
);

// File: tb/sim_rand_victim_gen.sv
`timescale 1ns/1ps
module sim_rand_victim_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wired_we = 1'b0;
  logic [4:0] wired_wdata = '0;
  logic       rw_sample = 1'b0;
  logic [3:0] rand_idx;
  logic [4:0] wired_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [15:0] m_sr;
  int          m_idx;
  int          m_floor;
  logic [15:0] seen;

  always #2.5 clk = ~clk;

  rand_victim_gen u0 (
    .clk(clk), .rst_n(rst_n), .wired_we(wired_we), .wired_wdata(wired_wdata),
    .rw_sample(rw_sample), .rand_idx(rand_idx), .wired_rdata(wired_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic tick(input bit we, input int wd, input bit smp);
    string tag;
    bit    skip;
    wired_we    = we;
    wired_wdata = 5'(wd);
    rw_sample   = smp;
    @(posedge clk);
    skip = m_sr[15];
    if (we) begin
      m_floor = wd; m_idx = 15; tag = "R6";
    end else if (m_floor > 15) begin
      tag = "R7";
    end else if (smp || !skip) begin
      if (m_idx <= m_floor) begin m_idx = 15; tag = "R4"; end
      else begin m_idx = m_idx - 1; tag = smp ? "R8" : "R3"; end
    end else begin
      tag = "R2 R9";
    end
    m_sr = {m_sr[14:0], m_sr[15] ^ m_sr[13] ^ m_sr[12] ^ m_sr[10]};
    @(negedge clk);
    wired_we  = 1'b0;
    rw_sample = 1'b0;
    check(tag, int'(rand_idx), m_idx);
    check("R6 floor", int'(wired_rdata), m_floor);
    if (m_floor <= 15 && int'(rand_idx) < int'(wired_rdata))
      check("R5", int'(rand_idx), m_floor);
    seen[rand_idx] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_sr = 16'hACE1; m_idx = 15; m_floor = 0; seen = '0;
    repeat (3) @(negedge clk);
    check("R1 idx", int'(rand_idx), 15);
    check("R1 floor", int'(wired_rdata), 0);
    rst_n = 1'b1;
    check("R1 after release", int'(rand_idx), 15);

    // R10: floor 0, every entry must appear
    for (int i = 0; i < 120; i++) tick(1'b0, 0, 1'b0);
    check("R10 coverage", int'(seen), 16'hFFFF);

    // sweep the floor across normal, single-entry and out-of-range values
    for (int w = 0; w < 18; w++) begin
      tick(1'b1, w, 1'b0);
      for (int i = 0; i < 50; i++) tick(1'b0, 0, 1'b0);
      for (int i = 0; i < 30; i++) tick(1'b0, 0, (i % 2) == 0);
      for (int i = 0; i < 6; i++)  tick(1'b0, 0, 1'b1);
    end

    // write in the middle of a run; strobe together with a write
    tick(1'b1, 3, 1'b0);
    for (int i = 0; i < 7; i++) tick(1'b0, 0, 1'b1);
    tick(1'b1, 9, 1'b1);
    for (int i = 0; i < 20; i++) tick(1'b0, 0, 1'b1);

    // async reset in mid-run returns to reset state
    rst_n = 1'b0;
    #1;
    check("R1 async idx", int'(rand_idx), 15);
    check("R1 async floor", int'(wired_rdata), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule